// File: doc/BRIEF.md
# Sound CPU I/O Port Decoder with Host Mailbox

This block sits on the I/O bus of an audio co-processor. It decodes the low byte of each port address and sends the access to one of three places. The first is a byte-wide command/result mailbox shared with the main (host) processor. The second is the register interface of an FM synthesis chip, with separate control and data strobes for its two register halves. The third is a set of bank-select strobes that a memory banking unit elsewhere uses to remap the co-processor's address window.

The host writes a command byte, which raises a pending flag. The co-processor reads the command port to fetch the byte, and that read drops the flag. The co-processor answers by writing a result byte, which the host reads at any time. The block also holds the co-processor's maskable interrupt request and its non-maskable interrupt request. The host drives both. The co-processor's acknowledge retires the non-maskable request.

All read data and strobes are combinational from the current access. Mailbox and interrupt state are registered and take effect on the next rising clock edge.

Top module: `snd_io_hub`

## Requirements
- R1: After reset, `cmd_pending`, `cpu_irq` and `cpu_nmi` are 0, and `host_result` and the command byte are 0x00.
- R2: A host command write (`host_cmd_we`) stores `host_cmd_data` and sets `cmd_pending` at the next edge. A CPU read of port 0x00 returns the stored byte in the same cycle and clears `cmd_pending` at the next edge. When both happen in one cycle, the read returns the old byte, and afterwards the flag is 1 and the new byte is held.
- R3: CPU reads of ports 0x04, 0x06 and 0x05 return `fm_stat_a`, `fm_stat_b` and `fm_rdata` respectively. A read of 0x05 also pulses `fm_rd_stb` for that cycle.
- R4: CPU writes to ports 0x04, 0x05, 0x06 and 0x07 pulse `fm_we[0]`, `fm_we[1]`, `fm_we[2]` and `fm_we[3]` respectively, for that cycle only. These are control A, data A, control B and data B, and `fm_wdata` carries the written byte.
- R5: A CPU write to port 0x0C places the byte on `host_result` from the next edge, and it stays there until the next such write.
- R6: CPU reads of ports 0x08, 0x09, 0x0A and 0x0B pulse `bank_stb[3]`, `bank_stb[2]`, `bank_stb[1]` and `bank_stb[0]` respectively, and return 0x00. `bank_page` carries the upper port-address byte.
- R7: A read of any port not listed in R2, R3 or R6 returns 0x00. A write to any port not listed in R4 or R5 raises no strobe and leaves `host_result` unchanged.
- R8: Only bits 7:0 of the port address take part in decoding. Any upper byte gives the same result as 0x00.
- R9: `host_nmi_set` raises `cpu_nmi` at the next edge. It stays high until a cycle with `cpu_nmi_ack` and no set, and then it falls at the next edge. When set and acknowledge come in the same cycle, set wins.
- R10: `host_irq_set` raises `cpu_irq` and `host_irq_clr` lowers it at the next edge, with set winning a tie. Neither input affects `cpu_nmi`.
- R11: No FM, bank or mailbox strobe is active in a cycle without the matching `cpu_rd` or `cpu_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_port | input | 16 | CPU I/O port address |
| cpu_rd | input | 1 | CPU I/O read strobe |
| cpu_wr | input | 1 | CPU I/O write strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data |
| host_cmd_we | input | 1 | Host command write |
| host_cmd_data | input | 8 | Host command byte |
| cmd_pending | output | 1 | Command waiting for the CPU |
| host_result | output | 8 | Result byte for the host |
| host_nmi_set | input | 1 | Host raises NMI request |
| host_irq_set | input | 1 | Host raises IRQ request |
| host_irq_clr | input | 1 | Host lowers IRQ request |
| cpu_nmi_ack | input | 1 | CPU acknowledges NMI |
| cpu_irq | output | 1 | Maskable interrupt request |
| cpu_nmi | output | 1 | Non-maskable interrupt request |
| fm_stat_a | input | 8 | FM chip status A |
| fm_stat_b | input | 8 | FM chip status B |
| fm_rdata | input | 8 | FM chip read-data register |
| fm_rd_stb | output | 1 | FM read-data access strobe |
| fm_we | output | 4 | FM write strobes: ctl A, data A, ctl B, data B |
| fm_wdata | output | 8 | FM write data |
| bank_stb | output | 4 | Bank-select strobes |
| bank_page | output | 8 | Upper port byte for bank selection |

## Verification
The decoder is driven with every decoded port, read and written. Distinct byte values on the three FM inputs show whether a read is routed to the wrong source. Walking the four bank and four FM-write ports shows whether the strobe order is reversed or shifted. Ports next to the decoded ones (0x01, 0x07 read, 0x0C read, 0x0D, 0xFF), and decoded low bytes with a non-zero upper byte, separate a full-width compare from a low-byte one and catch decode ranges that are too wide. Mailbox and interrupt tests apply set and clear alone and in the same cycle, which tells a set-wins order from a clear-wins order.

// File: rtl/sio_pkg.sv
package sio_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned FM_REGS = 4;

  typedef logic [BYTE_W-1:0] byte_t;

  // Decoded access events for one CPU cycle
  typedef struct packed {
    logic                cmd_rd;
    logic                sta_a_rd;
    logic                dat_rd;
    logic                sta_b_rd;
    logic                result_wr;
    logic [FM_REGS-1:0]  fm_wr;
  } sio_hit_t;

  // Port number that strobes bank k; the highest bank sits at the lowest port
  function automatic byte_t bank_port(input byte_t base, input int unsigned n, input int unsigned k);
    return base + byte_t'(n - 1 - k);
  endfunction

  // Port number of FM register r (ctl A, data A, ctl B, data B)
  function automatic byte_t fm_port(input byte_t base, input int unsigned r);
    return base + byte_t'(r);
  endfunction

  // Next state of a set/clear flag where set wins
  function automatic logic set_wins(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/sio_decode.sv
module sio_decode
  import sio_pkg::*;
#(
  parameter int unsigned N_BANKS     = 4,
  parameter byte_t       CMD_PORT    = 8'h00,
  parameter byte_t       FM_PORT     = 8'h04,
  parameter byte_t       BANK_PORT   = 8'h08,
  parameter byte_t       RESULT_PORT = 8'h0C
) (
  input  byte_t              port_lo,
  input  logic               rd,
  input  logic               wr,
  output sio_hit_t           hit,
  output logic [N_BANKS-1:0] bank_stb
);

  always_comb begin
    hit           = '0;
    hit.cmd_rd    = rd && (port_lo == CMD_PORT);
    hit.sta_a_rd  = rd && (port_lo == fm_port(FM_PORT, 0));
    hit.dat_rd    = rd && (port_lo == fm_port(FM_PORT, 1));
    hit.sta_b_rd  = rd && (port_lo == fm_port(FM_PORT, 2));
    hit.result_wr = wr && (port_lo == RESULT_PORT);
    for (int r = 0; r < FM_REGS; r++) begin
      hit.fm_wr[r] = wr && (port_lo == fm_port(FM_PORT, r));
    end
  end

  for (genvar k = 0; k < N_BANKS; k++) begin : g_bank
    assign bank_stb[k] = rd && (port_lo == bank_port(BANK_PORT, N_BANKS, k));
  end

endmodule

// File: rtl/sio_mailbox.sv
module sio_mailbox
  import sio_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  host_we,
  input  byte_t host_data,
  input  logic  cpu_take,
  input  logic  res_we,
  input  byte_t res_data,
  output byte_t cmd_q,
  output logic  pending,
  output byte_t result_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      pending  <= 1'b0;
      result_q <= '0;
    end else begin
      if (host_we) begin
        cmd_q   <= host_data;
        pending <= 1'b1;
      end else if (cpu_take) begin
        pending <= 1'b0;
      end
      if (res_we) begin
        result_q <= res_data;
      end
    end
  end

endmodule

// File: rtl/sio_irq_ctl.sv
module sio_irq_ctl
  import sio_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_set,
  input  logic nmi_ack,
  input  logic irq_set,
  input  logic irq_clr,
  output logic irq,
  output logic nmi
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq <= 1'b0;
      nmi <= 1'b0;
    end else begin
      irq <= set_wins(irq, irq_set, irq_clr);
      nmi <= set_wins(nmi, nmi_set, nmi_ack);
    end
  end

endmodule

// File: rtl/snd_io_hub.sv
module snd_io_hub
  import sio_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned N_BANKS     = 4,
  parameter byte_t       CMD_PORT    = 8'h00,
  parameter byte_t       FM_PORT     = 8'h04,
  parameter byte_t       BANK_PORT   = 8'h08,
  parameter byte_t       RESULT_PORT = 8'h0C
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         cpu_port,
  input  logic                      cpu_rd,
  input  logic                      cpu_wr,
  input  logic [7:0]                cpu_wdata,
  output logic [7:0]                cpu_rdata,
  input  logic                      host_cmd_we,
  input  logic [7:0]                host_cmd_data,
  output logic                      cmd_pending,
  output logic [7:0]                host_result,
  input  logic                      host_nmi_set,
  input  logic                      host_irq_set,
  input  logic                      host_irq_clr,
  input  logic                      cpu_nmi_ack,
  output logic                      cpu_irq,
  output logic                      cpu_nmi,
  input  logic [7:0]                fm_stat_a,
  input  logic [7:0]                fm_stat_b,
  input  logic [7:0]                fm_rdata,
  output logic                      fm_rd_stb,
  output logic [3:0]                fm_we,
  output logic [7:0]                fm_wdata,
  output logic [N_BANKS-1:0]        bank_stb,
  output logic [ADDR_W-BYTE_W-1:0]  bank_page
);

  sio_hit_t hit;
  byte_t    cmd_q;
  logic     cmd_take_w;
  logic     result_we_w;

  sio_decode #(
    .N_BANKS(N_BANKS), .CMD_PORT(CMD_PORT), .FM_PORT(FM_PORT),
    .BANK_PORT(BANK_PORT), .RESULT_PORT(RESULT_PORT)
  ) i_dec (
    .port_lo  (cpu_port[BYTE_W-1:0]),
    .rd       (cpu_rd),
    .wr       (cpu_wr),
    .hit      (hit),
    .bank_stb (bank_stb)
  );

  assign cmd_take_w  = hit.cmd_rd;
  assign result_we_w = hit.result_wr;

  sio_mailbox i_mbox (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_we   (host_cmd_we),
    .host_data (host_cmd_data),
    .cpu_take  (cmd_take_w),
    .res_we    (result_we_w),
    .res_data  (cpu_wdata),
    .cmd_q     (cmd_q),
    .pending   (cmd_pending),
    .result_q  (host_result)
  );

  sio_irq_ctl i_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .nmi_set (host_nmi_set),
    .nmi_ack (cpu_nmi_ack),
    .irq_set (host_irq_set),
    .irq_clr (host_irq_clr),
    .irq     (cpu_irq),
    .nmi     (cpu_nmi)
  );

  // Read return path; bank ports and undecoded ports read as zero
  always_comb begin
    cpu_rdata = '0;
    if (hit.cmd_rd)        cpu_rdata = cmd_q;
    else if (hit.sta_a_rd) cpu_rdata = fm_stat_a;
    else if (hit.dat_rd)   cpu_rdata = fm_rdata;
    else if (hit.sta_b_rd) cpu_rdata = fm_stat_b;
  end

  assign fm_rd_stb = hit.dat_rd;
  assign fm_we     = hit.fm_wr;
  assign fm_wdata  = cpu_wdata;
  assign bank_page = cpu_port[ADDR_W-1:BYTE_W];

endmodule

// File: rtl/sio_checker.sv
module sio_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_rd,
  input logic       cpu_wr,
  input logic       host_cmd_we,
  input logic       cmd_take_w,
  input logic       result_we_w,
  input logic       cmd_pending,
  input logic [7:0] host_result,
  input logic       host_nmi_set,
  input logic       host_irq_set,
  input logic       host_irq_clr,
  input logic       cpu_nmi_ack,
  input logic       cpu_irq,
  input logic       cpu_nmi,
  input logic       fm_rd_stb,
  input logic [3:0] fm_we,
  input logic [3:0] bank_stb
);

  AST_CMD_SETS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    host_cmd_we |=> cmd_pending); // R2
  AST_TAKE_CLEARS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_take_w && !host_cmd_we) |=> !cmd_pending); // R2
  AST_FM_WE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fm_we)); // R4
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !result_we_w |=> $stable(host_result)); // R5
  AST_BANK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_stb)); // R6
  AST_NMI_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_nmi && !cpu_nmi_ack) |=> cpu_nmi); // R9
  AST_NMI_SET: assert property (@(posedge clk) disable iff (!rst_n)
    host_nmi_set |=> cpu_nmi); // R9
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (host_irq_clr && !host_irq_set) |=> !cpu_irq); // R10
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq_set |=> cpu_irq); // R10
  AST_RD_STROBES_NEED_RD: assert property (@(posedge clk) disable iff (!rst_n)
    ((|bank_stb) || fm_rd_stb || cmd_take_w) |-> cpu_rd); // R11
  AST_WR_STROBES_NEED_WR: assert property (@(posedge clk) disable iff (!rst_n)
    ((|fm_we) || result_we_w) |-> cpu_wr); // R11

endmodule

bind snd_io_hub sio_checker i_chk (
  .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
  .host_cmd_we(host_cmd_we), .cmd_take_w(cmd_take_w), .result_we_w(result_we_w),
  .cmd_pending(cmd_pending), .host_result(host_result),
  .host_nmi_set(host_nmi_set), .host_irq_set(host_irq_set), .host_irq_clr(host_irq_clr),
  .cpu_nmi_ack(cpu_nmi_ack), .cpu_irq(cpu_irq), .cpu_nmi(cpu_nmi),
  .fm_rd_stb(fm_rd_stb), .fm_we(fm_we), .bank_stb(bank_stb)
);

// File: tb/test_snd_io_hub.sv
module test_snd_io_hub;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_port;
  logic        cpu_rd, cpu_wr;
  logic [7:0]  cpu_wdata, cpu_rdata;
  logic        host_cmd_we;
  logic [7:0]  host_cmd_data;
  logic        cmd_pending;
  logic [7:0]  host_result;
  logic        host_nmi_set, host_irq_set, host_irq_clr, cpu_nmi_ack;
  logic        cpu_irq, cpu_nmi;
  logic [7:0]  fm_stat_a, fm_stat_b, fm_rdata;
  logic        fm_rd_stb;
  logic [3:0]  fm_we;
  logic [7:0]  fm_wdata;
  logic [3:0]  bank_stb;
  logic [7:0]  bank_page;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  snd_io_hub i_snd_io_hub (.*);

  task automatic check(input string req, input string what, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, actual, expected);
    end
  endtask

  task automatic idle();
    cpu_port = '0; cpu_rd = 0; cpu_wr = 0; cpu_wdata = '0;
    host_cmd_we = 0; host_cmd_data = '0;
    host_nmi_set = 0; host_irq_set = 0; host_irq_clr = 0; cpu_nmi_ack = 0;
  endtask

  // Drive a CPU access from the falling edge, settle, leave it through the next rising edge
  task automatic cpu_go(input logic rd, input logic wr, input logic [15:0] port, input logic [7:0] d);
    @(negedge clk);
    idle();
    cpu_port = port; cpu_rd = rd; cpu_wr = wr; cpu_wdata = d;
    #1;
  endtask

  task automatic finish_cycle();
    @(negedge clk);
    idle();
    #1;
  endtask

  task automatic t_reset();
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check("R1", "pending", cmd_pending, 0);
    check("R1", "irq", cpu_irq, 0);
    check("R1", "nmi", cpu_nmi, 0);
    check("R1", "result", host_result, 0);
    cpu_go(1, 0, 16'h0000, 8'h00);
    check("R1", "cmd byte", cpu_rdata, 0);
    finish_cycle();
  endtask

  task automatic t_mailbox();
    @(negedge clk); idle(); host_cmd_we = 1; host_cmd_data = 8'h3C;
    finish_cycle();
    check("R2", "pending after host write", cmd_pending, 1);
    cpu_go(1, 0, 16'h0000, 8'h00);
    check("R2", "cmd read data", cpu_rdata, 8'h3C);
    finish_cycle();
    check("R2", "pending after cpu read", cmd_pending, 0);
    // collision: host write and CPU read together
    @(negedge clk); idle(); host_cmd_we = 1; host_cmd_data = 8'h11;
    finish_cycle();
    cpu_go(1, 0, 16'h0000, 8'h00);
    host_cmd_we = 1; host_cmd_data = 8'h22; #1;
    check("R2", "collision old byte", cpu_rdata, 8'h11);
    finish_cycle();
    check("R2", "collision pending", cmd_pending, 1);
    cpu_go(1, 0, 16'h0000, 8'h00);
    check("R2", "collision new byte", cpu_rdata, 8'h22);
    finish_cycle();
    check("R2", "pending cleared", cmd_pending, 0);
  endtask

  task automatic t_fm_reads();
    cpu_go(1, 0, 16'h0004, 8'h00);
    check("R3", "status A", cpu_rdata, 8'hA1);
    check("R3", "no rd strobe on 04", fm_rd_stb, 0);
    cpu_go(1, 0, 16'h0005, 8'h00);
    check("R3", "read data", cpu_rdata, 8'hD5);
    check("R3", "rd strobe on 05", fm_rd_stb, 1);
    cpu_go(1, 0, 16'h0006, 8'h00);
    check("R3", "status B", cpu_rdata, 8'hB6);
    finish_cycle();
  endtask

  task automatic t_fm_writes();
    for (int r = 0; r < 4; r++) begin
      cpu_go(0, 1, 16'(4 + r), 8'(8'h70 + r));
      check("R4", "fm_we", fm_we, 1 << r);
      check("R4", "fm_wdata", fm_wdata, 8'h70 + r);
      check("R11", "no bank strobe on write", bank_stb, 0);
    end
    finish_cycle();
    check("R4", "fm_we after access", fm_we, 0);
  endtask

  task automatic t_result();
    cpu_go(0, 1, 16'h000C, 8'h9E);
    finish_cycle();
    check("R5", "result latched", host_result, 8'h9E);
    repeat (3) @(negedge clk);
    #1;
    check("R5", "result held", host_result, 8'h9E);
  endtask

  task automatic t_banks();
    for (int p = 0; p < 4; p++) begin
      cpu_go(1, 0, {8'(8'h40 + p), 8'(8'h08 + p)}, 8'h00);
      check("R6", "bank strobe", bank_stb, 1 << (3 - p));
      check("R6", "bank read data", cpu_rdata, 0);
      check("R6", "bank page", bank_page, 8'h40 + p);
    end
    cpu_go(0, 1, 16'h0008, 8'h55);
    check("R11", "no bank strobe on write", bank_stb, 0);
    finish_cycle();
  endtask

  task automatic t_undecoded();
    cpu_go(1, 0, 16'h0001, 8'h00); check("R7", "read 01", cpu_rdata, 0);
    cpu_go(1, 0, 16'h0007, 8'h00); check("R7", "read 07", cpu_rdata, 0);
    cpu_go(1, 0, 16'h000C, 8'h00); check("R7", "read 0C", cpu_rdata, 0);
    cpu_go(1, 0, 16'h00FF, 8'h00); check("R7", "read FF", cpu_rdata, 0);
    check("R7", "no strobes on FF", {fm_rd_stb, fm_we, bank_stb}, 0);
    cpu_go(0, 1, 16'h000D, 8'hEE);
    check("R7", "write 0D strobes", {fm_we, bank_stb}, 0);
    cpu_go(0, 1, 16'h0000, 8'hEE);
    check("R7", "write 00 strobes", {fm_we, bank_stb}, 0);
    finish_cycle();
    check("R7", "result unchanged", host_result, 8'h9E);
    check("R7", "pending unchanged", cmd_pending, 0);
  endtask

  task automatic t_upper_byte();
    cpu_go(1, 0, 16'h3704, 8'h00); check("R8", "status A with upper", cpu_rdata, 8'hA1);
    cpu_go(1, 0, 16'hFF06, 8'h00); check("R8", "status B with upper", cpu_rdata, 8'hB6);
    cpu_go(0, 1, 16'h8107, 8'h33); check("R8", "data B write with upper", fm_we, 4'b1000);
    cpu_go(1, 0, 16'h0104, 8'h00); check("R8", "no bank on 0104", bank_stb, 0);
    cpu_go(0, 1, 16'hC30C, 8'h47);
    finish_cycle();
    check("R8", "result with upper", host_result, 8'h47);
  endtask

  task automatic t_nmi();
    @(negedge clk); idle(); host_nmi_set = 1;
    finish_cycle();
    check("R9", "nmi raised", cpu_nmi, 1);
    repeat (2) @(negedge clk);
    #1;
    check("R9", "nmi held", cpu_nmi, 1);
    @(negedge clk); idle(); host_nmi_set = 1; cpu_nmi_ack = 1;
    finish_cycle();
    check("R9", "set wins over ack", cpu_nmi, 1);
    @(negedge clk); idle(); cpu_nmi_ack = 1;
    finish_cycle();
    check("R9", "ack clears", cpu_nmi, 0);
  endtask

  task automatic t_irq();
    @(negedge clk); idle(); host_irq_set = 1;
    finish_cycle();
    check("R10", "irq set", cpu_irq, 1);
    check("R10", "nmi untouched", cpu_nmi, 0);
    @(negedge clk); idle(); host_irq_set = 1; host_irq_clr = 1;
    finish_cycle();
    check("R10", "set wins over clear", cpu_irq, 1);
    @(negedge clk); idle(); host_irq_clr = 1;
    finish_cycle();
    check("R10", "irq cleared", cpu_irq, 0);
    check("R10", "nmi still low", cpu_nmi, 0);
  endtask

  initial begin
    fm_stat_a = 8'hA1; fm_stat_b = 8'hB6; fm_rdata = 8'hD5;
    t_reset();
    t_mailbox();
    t_fm_reads();
    t_fm_writes();
    t_result();
    t_banks();
    t_undecoded();
    t_upper_byte();
    t_nmi();
    t_irq();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule